// File: doc/BRIEF.md
# Scan Test Clock Controller

This block chooses the clock that scan-tested logic receives. Outside test mode the fast functional clock goes straight to the output. In test mode the block has two phases. While scan enable is high, the slow shift clock drives the output so that the scan chains can load and unload. When scan enable falls, the block enters capture and releases a short burst of fast-clock pulses. The burst is one pulse for stuck-at patterns and two back-to-back pulses for at-speed patterns.

Scan enable is brought into the fast-clock domain through a two-flop synchronizer. A three-bit thermometer register then fills with ones, one per fast cycle. The enable decoded from that register is held in a latch that is open only while the fast clock is low, and the latch drives an AND clock gate. The choice between the shift clock and the gated fast clock is held in a second latch. That latch only updates while both clocks are low, so every output pulse has its full width.

Top module: `scan_clk_ctrl`

## Requirements
- R1: With test_mode at 0, clk_out equals fast_clk at all times. scan_en, at_speed and shift_clk have no effect on it.
- R2: With test_mode at 1 and scan_en at 1, each shift_clk pulse produces exactly one clk_out pulse of the same width, and no fast_clk pulse reaches clk_out.
- R3: After scan_en falls in test mode, clk_out stays low through the first three rising edges of fast_clk. The first capture pulse starts at the fourth rising edge.
- R4: With at_speed at 0, exactly one capture pulse is released for each fall of scan_en.
- R5: With at_speed at 1, exactly two capture pulses are released for each fall of scan_en, on consecutive fast_clk cycles.
- R6: Once the burst is over, clk_out stays low for as long as scan_en stays at 0, including while shift_clk toggles.
- R7: After scan_en has been high for at least three fast_clk cycles, a new fall of scan_en produces a new capture burst.
- R8: While rst_n is low, no capture pulse is released. After reset, no capture pulse is released until scan_en has been seen at 1.
- R9: Every capture pulse on clk_out is high for the full high phase of fast_clk (5 ns at 100 MHz).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset. Clears the synchronizer and the fill register. |
| test_mode | input | 1 | 1 selects scan test clocking, 0 passes the functional clock through. |
| scan_en | input | 1 | 1 for the shift phase, 0 for the capture phase. |
| at_speed | input | 1 | 0 gives one capture pulse, 1 gives two. |
| shift_clk | input | 1 | Slow clock used for shifting. |
| fast_clk | input | 1 | Fast functional clock, also the source of capture pulses. |
| clk_out | output | 1 | Clock delivered to the logic under test. |

## Verification
A fill register stuck or advancing wrongly shows up at clk_out as a missing, extra or early capture pulse. The pulse count over the burst exposes this within about five fast cycles of scan_en falling. A synchronizer of the wrong depth moves the first pulse off the fourth rising edge, and the bench checks the count edge by edge at that point. A faulty select or gate latch shows as shift pulses leaking into capture, fast pulses leaking into shift, or a capture pulse shorter than half a fast period. Each of these appears on the first burst after the fault.

// File: rtl/scan_clk_ctrl.sv
module scan_clk_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic test_mode,
  input  logic scan_en,
  input  logic at_speed,
  input  logic shift_clk,
  input  logic fast_clk,
  output logic clk_out
);
  localparam int FILL_W = 3;

  logic [SYNC_STAGES-1:0] se_pipe;
  logic                   se_sync;
  logic                   armed;
  logic [FILL_W-1:0]      fill;
  logic                   gate_en;
  logic                   en_lat;
  logic                   shift_sel;
  logic                   gated_fast;

  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n) se_pipe <= '0;
    else        se_pipe <= {se_pipe[SYNC_STAGES-2:0], scan_en};

  assign se_sync = se_pipe[SYNC_STAGES-1];

  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n) begin
      fill  <= '0;
      armed <= 1'b0;
    end else if (se_sync) begin
      fill  <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      fill  <= {fill[FILL_W-2:0], 1'b1};
    end

  assign gate_en = fill[0] & ~(at_speed ? fill[2] : fill[1]);

  always_latch
    if (!fast_clk) en_lat = gate_en;

  assign gated_fast = fast_clk & en_lat;

  always_latch
    if (!fast_clk && !shift_clk) shift_sel = scan_en;

  assign clk_out = test_mode ? ((shift_clk & shift_sel) | gated_fast) : fast_clk;

  logic [1:0] cap_cnt;
  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n)        cap_cnt <= '0;
    else if (se_sync)  cap_cnt <= '0;
    else if (gate_en && cap_cnt != 2'd3) cap_cnt <= cap_cnt + 2'd1;

  // R2
  shift_closed_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    se_sync |=> !gate_en);

  // R3
  open_after_low_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(!se_sync));

  // R5
  cap_limit_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    gate_en |-> cap_cnt < 2'd2);

  // R6
  fill_keep_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    !se_sync |=> (fill & $past(fill)) == $past(fill));
endmodule

// File: tb/sim_scan_clk_ctrl.sv
`timescale 1ns/1ps
module sim_scan_clk_ctrl;
  logic rst_n = 1'b0, test_mode = 1'b1, scan_en = 1'b1, at_speed = 1'b0;
  logic shift_clk = 1'b0, fast_clk = 1'b0;
  logic clk_out;
  int   checks = 0, fails = 0, edges = 0;
  bit   done = 0;
  realtime t_rise = 0, last_w = 0;

  // {at_speed, shift pulses[3:0], expected capture pulses[3:0]}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 4'd3, 4'd1}, {1'b1, 4'd3, 4'd2}, {1'b0, 4'd1, 4'd1},
    {1'b1, 4'd5, 4'd2}, {1'b1, 4'd0, 4'd2}, {1'b0, 4'd2, 4'd1}};

  scan_clk_ctrl u0 (.rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
    .at_speed(at_speed), .shift_clk(shift_clk), .fast_clk(fast_clk), .clk_out(clk_out));

  always #5 fast_clk = ~fast_clk;
  always @(posedge clk_out) begin edges++; t_rise = $realtime; end
  always @(negedge clk_out) last_w = $realtime - t_rise;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge fast_clk);
    #2;
  endtask

  task automatic shift_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      shift_clk = 1'b1; #20; shift_clk = 1'b0; #20;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #500000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R8: reset holds the gate closed even in capture
    test_mode = 1'b1; scan_en = 1'b0;
    edges = 0; cyc(8);
    chk(edges == 0, "R8 during reset", edges, 0);
    chk(clk_out == 1'b0, "R8 reset output", int'(clk_out), 0);
    rst_n = 1'b1; cyc(10);
    chk(edges == 0, "R8 no capture before shift", edges, 0);
    scan_en = 1'b1; cyc(4);
    @(negedge fast_clk); #2; scan_en = 1'b0; edges = 0;
    cyc(8);
    chk(edges == 1, "R8 capture after shift seen", edges, 1);
    scan_en = 1'b1; cyc(4);

    // Vector table
    foreach (VEC[k]) begin
      at_speed = VEC[k][8];
      scan_en = 1'b1; cyc(4);
      edges = 0;
      shift_pulses(int'(VEC[k][7:4]));
      #3;
      chk(edges == int'(VEC[k][7:4]), "R2 shift pulses", edges, int'(VEC[k][7:4]));
      @(negedge fast_clk); #2; scan_en = 1'b0; edges = 0;
      cyc(10);
      chk(edges == int'(VEC[k][3:0]), at_speed ? "R5 at-speed count" : "R4 stuck-at count",
          edges, int'(VEC[k][3:0]));
      chk(last_w > 4.9 && last_w < 5.1, "R9 pulse width ps", int'(last_w * 1000), 5000);
      shift_pulses(3);
      cyc(6);
      chk(edges == int'(VEC[k][3:0]), "R6 closed after burst", edges, int'(VEC[k][3:0]));
      scan_en = 1'b1; cyc(4);   // R7: the next vector re-arms here
    end

    // R3 and R5: first pulse on fourth rising edge, second on the fifth
    at_speed = 1'b1; scan_en = 1'b1; cyc(4);
    @(negedge fast_clk); #2; scan_en = 1'b0; edges = 0;
    cyc(3);
    chk(edges == 0, "R3 quiet three edges", edges, 0);
    cyc(1);
    chk(edges == 1, "R3 first pulse edge four", edges, 1);
    cyc(1);
    chk(edges == 2, "R5 consecutive second pulse", edges, 2);
    cyc(1);
    chk(edges == 2, "R5 no third pulse", edges, 2);

    // R7: a fresh fall after re-arming gives a new burst
    scan_en = 1'b1; cyc(3);
    @(negedge fast_clk); #2; scan_en = 1'b0; edges = 0;
    cyc(8);
    chk(edges == 2, "R7 second burst", edges, 2);

    // R1: functional pass-through ignores the other inputs
    test_mode = 1'b0; shift_clk = 1'b1;
    for (int i = 0; i < 8; i++) begin
      scan_en = i[0]; at_speed = i[1];
      @(posedge fast_clk); #2;
      chk(clk_out == 1'b1, "R1 high phase", int'(clk_out), 1);
      @(negedge fast_clk); #2;
      chk(clk_out == 1'b0, "R1 low phase", int'(clk_out), 0);
    end
    shift_clk = 1'b0;
    finish_run();
  end
endmodule